// File: doc/BRIEF.md
# Edge-Triggered Lockout Glitch Filter

This block cleans up a single-bit signal that may carry spikes or contact
bounce. The first time the input changes level while the filter is idle,
the new level is passed to the output on the very clock edge that sees the
change, with no filtering delay. Right after that, the filter blanks its
input for a programmable number of clock ticks. During that window the
output is frozen, so any further toggling of the input cannot reach it.

The block is built from three parts:

- An edge detector compares the current input sample with the sample from the previous tick.
- A self-reloading lockout counter is started by a detected edge. It raises a lockout flag while it is running and a terminal flag when it reaches the window length.
- An output stage either takes the input or keeps its previous value, depending on the lockout flag.

When the window closes, the output takes whatever level the input then has.

The window length is an input port, so it can be held constant or changed at run time. Any value below one is treated as one. The input must already be synchronous to the clock.

Top module: `spike_lockout_filter`

## Requirements
- R1: While `rst_i` is high at a clock edge, the counter clears to zero and `dout_o` clears to 0. The stored previous input sample also clears to 0. After reset is released, `dout_o` reads 0 until an input level of 1 is accepted.
- R2: When no window is running, the value of `din_i` sampled at a clock edge appears on `dout_o` right after that same edge. This holds whether or not the sample differs from the previous one.
- R3: A level change of `din_i` accepted at edge k starts a blanking window. At edges k+1 through k+N, `dout_o` keeps the value it took at edge k, whatever `din_i` does. Here N is the effective window length.
- R4: The effective window length N equals `lock_len_i` when `lock_len_i` is 1 or more. At edge k+N+1 the filter is idle again, so an input change sampled at that edge passes to `dout_o` immediately.
- R5: A `lock_len_i` of 0 behaves the same as a `lock_len_i` of 1: there is exactly one blanked edge after an accepted change.
- R6: If `din_i` settled at a level different from `dout_o` during a window, `dout_o` takes that level at the first idle edge. That catch-up does not start a new window, so a change of `din_i` on the next edge also passes immediately.
- R7: While `din_i` stays constant and no window is running, the counter stays at zero and `dout_o` equals `din_i`. A later change is then passed at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one tick is the unit of the window length |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | 1 | Raw input bit, already synchronous to `clk_i` |
| lock_len_i | input | CNT_W | Blanking window length in ticks (0 treated as 1) |
| dout_o | output | 1 | Filtered output bit |

## Verification
The bench builds the filter with the default counter width of 16 bits. It applies window lengths of 0, 1, 2, 4 and 200. The values 0 and 1 reach the clamp that keeps a zero setting from disabling blanking. The values 2 and 4 allow a change to be placed on the last blanked edge and on the first idle edge, so both sides of the window boundary are tested. The value 200 holds a long window against constant input toggling, with the counter far above its low values but well inside its 16-bit range.

// File: rtl/spike_lockout_pkg.sv
package spike_lockout_pkg;

    // Default width of the lockout counter and of the window-length input.
    localparam int unsigned LOCK_CNT_W_DEF = 16;

    // State held by the edge detector: the previous input sample.
    typedef struct packed {
        logic prev;
    } edge_state_t;

    // State held by the output stage: the filtered output level.
    typedef struct packed {
        logic level;
    } out_state_t;

endpackage

// File: rtl/spike_lockout_edge.sv
module spike_lockout_edge
    import spike_lockout_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic din_i,
    output logic edge_o
);

    edge_state_t st_d;
    edge_state_t st_q;

    // Next-state logic: remember the current sample for the next tick.
    always_comb begin
        st_d      = st_q;
        st_d.prev = din_i;
        if (rst_i) begin
            st_d.prev = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // An edge is a difference between this sample and the last one.
    // The result is combinational, so it acts in the same cycle.
    assign edge_o = din_i ^ st_q.prev;

endmodule

// File: rtl/spike_lockout_cnt.sv
module spike_lockout_cnt #(
    parameter int unsigned CNT_W = spike_lockout_pkg::LOCK_CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] lock_len_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             lock_o,
    output logic             term_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d;
    cnt_state_t       st_q;
    logic [CNT_W-1:0] len_eff;
    logic             lock_w;
    logic             term_w;

    // A setting of zero is raised to one, so every accepted edge is
    // followed by at least one blanked tick.
    always_comb begin
        len_eff = lock_len_i;
        if (lock_len_i == CNT_ZERO) begin
            len_eff = CNT_ONE;
        end
    end

    // Status flags decoded from the current count.
    always_comb begin
        lock_w = (st_q.cnt != CNT_ZERO);
        term_w = (st_q.cnt >= len_eff);
    end

    // Next-state logic. The terminal flag has priority: it reloads the
    // count to zero. Otherwise the count advances while an edge is seen
    // or a window is running, and holds when neither is true.
    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.cnt = CNT_ZERO;
        end else if (term_w) begin
            st_d.cnt = CNT_ZERO;
        end else if (edge_i || lock_w) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    // State register.
    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign lock_o = lock_w;
    assign term_o = term_w;

endmodule

// File: rtl/spike_lockout_out.sv
module spike_lockout_out
    import spike_lockout_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic din_i,
    input  logic lock_i,
    output logic dout_o
);

    out_state_t st_d;
    out_state_t st_q;

    // Next-state logic. During a window the output is frozen. When idle,
    // the output takes the input level, with or without an edge.
    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.level = 1'b0;
        end else if (!lock_i) begin
            st_d.level = din_i;
        end
    end

    // State register.
    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign dout_o = st_q.level;

endmodule

// File: rtl/spike_lockout_filter.sv
module spike_lockout_filter #(
    parameter int unsigned CNT_W = spike_lockout_pkg::LOCK_CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             din_i,
    input  logic [CNT_W-1:0] lock_len_i,
    output logic             dout_o
);

    logic             edge_w;
    logic [CNT_W-1:0] cnt_w;
    logic             lock_w;
    logic             term_w;

    spike_lockout_edge u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .din_i  (din_i),
        .edge_o (edge_w)
    );

    spike_lockout_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .edge_i     (edge_w),
        .lock_len_i (lock_len_i),
        .cnt_o      (cnt_w),
        .lock_o     (lock_w),
        .term_o     (term_w)
    );

    spike_lockout_out u_out (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .din_i  (din_i),
        .lock_i (lock_w),
        .dout_o (dout_o)
    );

endmodule

// File: rtl/spike_lockout_chk.sv
module spike_lockout_chk #(
    parameter int unsigned CNT_W = spike_lockout_pkg::LOCK_CNT_W_DEF
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             din_i,
    input logic [CNT_W-1:0] lock_len_i,
    input logic             dout_o,
    input logic [CNT_W-1:0] cnt_i,
    input logic             lock_i,
    input logic             term_i
);

    logic [CNT_W-1:0] len_ref;
    assign len_ref = (lock_len_i == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : lock_len_i;

    // R1: reset clears the count and the output.
    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (dout_o == 1'b0) && (cnt_i == '0));

    // R2: when idle, the sampled input appears on the output after the edge.
    p_follow_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !lock_i |=> (dout_o == $past(din_i)));

    // R3: during a window, the output is frozen.
    p_hold_locked_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        lock_i |=> $stable(dout_o));

    // R4: once the count reaches the effective length, it reloads to zero.
    p_reload_at_len_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_i >= len_ref) |=> (cnt_i == '0));

    // R4: the terminal flag agrees with the window length seen by the checker.
    p_term_match_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        term_i |-> (cnt_i >= len_ref));

    // R5: a window always starts at a count of one, so even a zero setting
    // gives at least one blanked tick.
    p_window_start_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_i) |-> (cnt_i == {{(CNT_W-1){1'b0}}, 1'b1}));

endmodule

bind spike_lockout_filter spike_lockout_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .din_i      (din_i),
    .lock_len_i (lock_len_i),
    .dout_o     (dout_o),
    .cnt_i      (cnt_w),
    .lock_i     (lock_w),
    .term_i     (term_w)
);

// File: tb/spike_lockout_filter_tb.sv
module spike_lockout_filter_tb;

    localparam int unsigned CNT_W      = 16;
    localparam time         CLK_PERIOD = 10;

    logic             clk_i = 1'b0;
    logic             rst_i = 1'b1;
    logic             din_i = 1'b0;
    logic [CNT_W-1:0] lock_len_i = 16'd4;
    logic             dout_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    spike_lockout_filter #(.CNT_W(CNT_W)) u_dut (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .din_i      (din_i),
        .lock_len_i (lock_len_i),
        .dout_o     (dout_o)
    );

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (dout_o !== exp) begin
            n_fails++;
            $display("FAIL %s: dout_o actual %b expected %b at %0t", req, dout_o, exp, $time);
        end
    endtask

    // Drive a sample at the falling edge, then wait just past the next rising edge.
    task automatic step(input logic v);
        @(negedge clk_i);
        din_i = v;
        @(posedge clk_i);
        #1;
    endtask

    task automatic idle(input logic v, input int n);
        for (int i = 0; i < n; i++) step(v);
    endtask

    task automatic t_reset();
        rst_i = 1'b1;
        din_i = 1'b0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_i = 1'b0;
        check(1'b0, "R1 reset output");
        step(1'b0);
        check(1'b0, "R1 after release");
    endtask

    task automatic t_pass_and_boundary();
        lock_len_i = 16'd4;
        idle(1'b0, 10);
        step(1'b1);
        check(1'b1, "R2 immediate pass");
        for (int i = 1; i <= 3; i++) begin
            step(1'b0);
            check(1'b1, "R3 blanked edge");
        end
        step(1'b1);
        check(1'b1, "R3 blanked edge 4");
        step(1'b0);
        check(1'b0, "R4 change on first idle edge passes");
    endtask

    task automatic t_last_blanked_catchup();
        lock_len_i = 16'd4;
        idle(1'b0, 10);
        step(1'b1);
        check(1'b1, "R2 pass");
        step(1'b1);
        step(1'b1);
        step(1'b1);
        check(1'b1, "R3 hold");
        step(1'b0);
        check(1'b1, "R3 change on last blanked edge ignored");
        step(1'b0);
        check(1'b0, "R6 catch-up at first idle edge");
        step(1'b1);
        check(1'b1, "R6 no new window after catch-up");
    endtask

    task automatic t_short_len(input logic [CNT_W-1:0] len, input string tag);
        lock_len_i = len;
        idle(1'b0, 10);
        step(1'b1);
        check(1'b1, {tag, " pass"});
        step(1'b0);
        check(1'b1, {tag, " one blanked edge"});
        step(1'b0);
        check(1'b0, {tag, " window over after one edge"});
    endtask

    task automatic t_len_two();
        lock_len_i = 16'd2;
        idle(1'b1, 10);
        step(1'b0);
        check(1'b0, "R2 falling pass");
        step(1'b1);
        check(1'b0, "R3 len2 edge1 held");
        step(1'b0);
        check(1'b0, "R3 len2 edge2 held");
        step(1'b1);
        check(1'b1, "R4 len2 idle edge passes");
    endtask

    task automatic t_steady();
        lock_len_i = 16'd3;
        idle(1'b1, 10);
        for (int i = 0; i < 20; i++) begin
            step(1'b1);
            check(1'b1, "R7 steady high follows");
        end
        step(1'b0);
        check(1'b0, "R7 change after steady passes");
    endtask

    task automatic t_long();
        lock_len_i = 16'd200;
        idle(1'b0, 210);
        step(1'b1);
        check(1'b1, "R2 pass before long window");
        for (int i = 1; i <= 200; i++) begin
            step(i[0]);
            if (dout_o !== 1'b1) check(1'b1, "R3 long window held");
        end
        check(1'b1, "R3 long window end held");
        step(1'b0);
        check(1'b0, "R4 long window idle edge passes");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_pass_and_boundary();
        t_last_blanked_catchup();
        t_short_len(16'd1, "R5 len1");
        t_short_len(16'd0, "R5 len0");
        t_len_two();
        t_steady();
        t_long();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run();
    end

endmodule